// File: doc/BRIEF.md
# Atomic Multi-Queue Descriptor Engine

The engine owns the descriptors of a set of queues (64 by default). Each queue is either a singly linked list of element indices or a ring buffer placed in a window of a shared element memory. Many unrelated requesters can share these queues. Each of them issues a single command: configure, add an element, or remove an element. The engine then carries out every dependent memory reference the command needs, in order, against an internal memory model with a fixed, parameterised latency.

Only one command is in progress at a time. While a multi-reference command runs, `busy` is high and any new command on the input is dropped. No requester can observe a half-updated queue. Commands that need no memory reference finish on the cycle they are accepted: configuration, adding to a full ring, and removing from an empty queue.

In a linked list, the element index doubles as the address of its link word. Bit ELEM_W of a link word flags a null pointer. In a ring, the slot for pointer p is at address base + (p mod size).

Top module: `qdesc_engine`

## Requirements
- R1: After reset `busy` and `rsp_valid` are low, and every queue behaves as an empty linked list, so a remove returns the empty flag.
- R2: A command is accepted when `cmd_valid` is high and `busy` is low. Opcode 0 configures the queue: `cfg_ring`=1 selects ring and 0 selects list, `cfg_base` sets the ring window and `cfg_size_lg` sets log2 of the ring size. It empties the queue even if the queue held elements. One cycle after acceptance `rsp_valid` and `rsp_ok` pulse, and `busy` stays low.
- R3: For a linked-list queue, opcode 1 appends `cmd_elem` and opcode 2 returns the elements in first-in first-out order on `rsp_elem` with `rsp_ok`. This holds with a single element and with several elements.
- R4: For a ring queue, opcodes 1 and 2 keep first-in first-out order across any number of pointer wraps. The storage is confined to base .. base+size-1.
- R5: Adding to a ring that holds size elements answers with `rsp_full` one cycle after acceptance, without raising `busy`, and leaves the ring's contents unchanged.
- R6: Removing from an empty queue answers with `rsp_empty` one cycle after acceptance, without raising `busy`, and changes nothing.
- R7: An add or remove that needs memory holds `busy` high from the cycle after acceptance until the cycle its response pulses. Commands presented during that time are ignored.
- R8: Each `rsp_valid` pulse carries exactly one of `rsp_ok`, `rsp_empty` and `rsp_full`. All three are low when `rsp_valid` is low.
- R9: Lists and rings of different queues operate independently in any mix and in any interleaving of commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 configure, 1 add, 2 remove |
| cmd_queue | input | $clog2(NUM_Q) | Queue number |
| cmd_elem | input | ELEM_W | Element to add |
| cfg_ring | input | 1 | Configure as ring (1) or list (0) |
| cfg_base | input | ELEM_W | Ring window base address |
| cfg_size_lg | input | $clog2(ELEM_W+1) | log2 of ring size |
| busy | output | 1 | Multi-reference command in progress |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Command completed |
| rsp_empty | output | 1 | Remove found queue empty |
| rsp_full | output | 1 | Add found ring full |
| rsp_elem | output | ELEM_W | Removed element |

## Verification
Most internal faults show up on the first remove that follows the damage. A lost link write, a wrong tail or a miscounted length returns the wrong element or a premature empty flag. That means one list drain or one ring wrap (at most size commands) exposes them. Pointer-mask and base errors appear once a ring wraps or a second ring shares the memory. A broken busy or atomicity path shows up within a single command: a dropped command takes effect, or the response arrives while `busy` is still high.

// File: rtl/qe_pkg.sv
package qe_pkg;
    typedef enum logic [1:0] {
        OP_CFG = 2'd0,
        OP_ENQ = 2'd1,
        OP_DEQ = 2'd2,
        OP_NOP = 2'd3
    } qe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LENQ_NULL = 3'd1,
        ST_LENQ_LINK = 3'd2,
        ST_LDEQ      = 3'd3,
        ST_RENQ      = 3'd4,
        ST_RDEQ      = 3'd5
    } qe_state_e;
endpackage

// File: rtl/qe_mem.sv
// Element memory with a fixed access latency: a request issued in cycle t
// completes (done high, rdata valid, write committed at that edge) in t+LAT.
module qe_mem #(
    parameter int AW  = 8,
    parameter int DW  = 9,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [LAT-1:0] vld_q;
    logic           we_q   [LAT];
    logic [AW-1:0]  addr_q [LAT];
    logic [DW-1:0]  data_q [LAT];
    logic [DW-1:0]  store  [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q[0] <= 1'b0;
        else        vld_q[0] <= req;
        we_q[0]   <= req_we;
        addr_q[0] <= req_addr;
        data_q[0] <= req_wdata;
    end

    for (genvar k = 1; k < LAT; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) vld_q[k] <= 1'b0;
            else        vld_q[k] <= vld_q[k-1];
            we_q[k]   <= we_q[k-1];
            addr_q[k] <= addr_q[k-1];
            data_q[k] <= data_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (vld_q[LAT-1] && we_q[LAT-1]) store[addr_q[LAT-1]] <= data_q[LAT-1];
    end

    assign done  = vld_q[LAT-1];
    assign rdata = store[addr_q[LAT-1]];
endmodule

// File: rtl/qe_desc_store.sv
// Register file of per-queue descriptors, one read and one write port.
module qe_desc_store #(
    parameter int NQ = 64,
    parameter int W  = 32,
    localparam int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] entry_q [NQ];

    for (genvar i = 0; i < NQ; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)                          entry_q[i] <= '0;
            else if (wr_en && wr_idx == QW'(i))  entry_q[i] <= wr_data;
        end
    end

    assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/qdesc_engine.sv
module qdesc_engine
    import qe_pkg::*;
#(
    parameter int NUM_Q   = 64,
    parameter int ELEM_W  = 8,
    parameter int MEM_LAT = 2,
    localparam int QW  = $clog2(NUM_Q),
    localparam int LGW = $clog2(ELEM_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [QW-1:0]     cmd_queue,
    input  logic [ELEM_W-1:0] cmd_elem,
    input  logic              cfg_ring,
    input  logic [ELEM_W-1:0] cfg_base,
    input  logic [LGW-1:0]    cfg_size_lg,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic              rsp_empty,
    output logic              rsp_full,
    output logic [ELEM_W-1:0] rsp_elem
);
    localparam int CW = ELEM_W + 1;   // element count width
    localparam int DW = ELEM_W + 1;   // memory word: null flag + pointer/element

    typedef struct packed {
        logic              ring;
        logic [ELEM_W-1:0] head;   // list head / ring read pointer
        logic [ELEM_W-1:0] tail;   // list tail / ring write pointer
        logic [CW-1:0]     cnt;
        logic [ELEM_W-1:0] base;
        logic [LGW-1:0]    lg;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef struct packed {
        qe_state_e         st;
        logic              pend;
        logic [QW-1:0]     q;
        desc_t             d;
        logic [ELEM_W-1:0] elem;
        logic              rv;
        logic              rok;
        logic              remp;
        logic              rfull;
        logic [ELEM_W-1:0] relem;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [DESC_W-1:0] rd_vec;
    desc_t             cur;
    logic              st_we;
    logic [QW-1:0]     st_idx;
    desc_t             st_wdata;
    logic              mem_req, mem_we, mem_done;
    logic [ELEM_W-1:0] mem_addr;
    logic [DW-1:0]     mem_wdata, mem_rdata;
    logic [CW-1:0]     idle_size, ring_mask;
    logic [ELEM_W-1:0] slot_rd, slot_wr;

    qe_desc_store #(.NQ(NUM_Q), .W(DESC_W)) u_desc (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cmd_queue),
        .rd_data (rd_vec),
        .wr_en   (st_we),
        .wr_idx  (st_idx),
        .wr_data (st_wdata)
    );

    qe_mem #(.AW(ELEM_W), .DW(DW), .LAT(MEM_LAT)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (mem_req),
        .req_we    (mem_we),
        .req_addr  (mem_addr),
        .req_wdata (mem_wdata),
        .done      (mem_done),
        .rdata     (mem_rdata)
    );

    assign cur       = desc_t'(rd_vec);
    assign idle_size = CW'(1) << cur.lg;
    assign ring_mask = (CW'(1) << c_q.d.lg) - CW'(1);
    assign slot_rd   = c_q.d.base + (c_q.d.head & ring_mask[ELEM_W-1:0]);
    assign slot_wr   = c_q.d.base + (c_q.d.tail & ring_mask[ELEM_W-1:0]);

    always_comb begin
        logic fin;
        logic ack;
        fin       = 1'b0;
        c_d       = c_q;
        c_d.rv    = 1'b0;
        c_d.rok   = 1'b0;
        c_d.remp  = 1'b0;
        c_d.rfull = 1'b0;
        st_we     = 1'b0;
        st_idx    = c_q.q;
        st_wdata  = c_q.d;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ack       = c_q.pend && mem_done;

        if (c_q.st != ST_IDLE) begin
            if (!c_q.pend) begin
                mem_req  = 1'b1;
                c_d.pend = 1'b1;
            end else if (mem_done) begin
                c_d.pend = 1'b0;
            end
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    c_d.q    = cmd_queue;
                    c_d.d    = cur;
                    c_d.elem = cmd_elem;
                    unique case (qe_op_e'(cmd_op))
                        OP_CFG: begin
                            st_we          = 1'b1;
                            st_idx         = cmd_queue;
                            st_wdata       = '0;
                            st_wdata.ring  = cfg_ring;
                            st_wdata.base  = cfg_base;
                            st_wdata.lg    = cfg_size_lg;
                            c_d.rv         = 1'b1;
                            c_d.rok        = 1'b1;
                        end
                        OP_ENQ: begin
                            if (cur.ring && cur.cnt == idle_size) begin
                                c_d.rv    = 1'b1;
                                c_d.rfull = 1'b1;
                            end else begin
                                c_d.st = cur.ring ? ST_RENQ : ST_LENQ_NULL;
                            end
                        end
                        OP_DEQ: begin
                            if (cur.cnt == '0) begin
                                c_d.rv   = 1'b1;
                                c_d.remp = 1'b1;
                            end else begin
                                c_d.st = cur.ring ? ST_RDEQ : ST_LDEQ;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_LENQ_NULL: begin
                mem_we    = 1'b1;
                mem_addr  = c_q.elem;
                mem_wdata = {1'b1, {ELEM_W{1'b0}}};
                if (ack) begin
                    if (c_q.d.cnt == '0) begin
                        c_d.d.head = c_q.elem;
                        c_d.d.tail = c_q.elem;
                        c_d.d.cnt  = CW'(1);
                        fin        = 1'b1;
                    end else begin
                        c_d.st = ST_LENQ_LINK;
                    end
                end
            end
            ST_LENQ_LINK: begin
                mem_we    = 1'b1;
                mem_addr  = c_q.d.tail;
                mem_wdata = {1'b0, c_q.elem};
                if (ack) begin
                    c_d.d.tail = c_q.elem;
                    c_d.d.cnt  = c_q.d.cnt + CW'(1);
                    fin        = 1'b1;
                end
            end
            ST_LDEQ: begin
                mem_addr = c_q.d.head;
                if (ack) begin
                    c_d.relem  = c_q.d.head;
                    c_d.d.head = mem_rdata[ELEM_W-1:0];
                    c_d.d.cnt  = mem_rdata[ELEM_W] ? '0 : c_q.d.cnt - CW'(1);
                    fin        = 1'b1;
                end
            end
            ST_RENQ: begin
                mem_we    = 1'b1;
                mem_addr  = slot_wr;
                mem_wdata = {1'b0, c_q.elem};
                if (ack) begin
                    c_d.d.tail = c_q.d.tail + ELEM_W'(1);
                    c_d.d.cnt  = c_q.d.cnt + CW'(1);
                    fin        = 1'b1;
                end
            end
            ST_RDEQ: begin
                mem_addr = slot_rd;
                if (ack) begin
                    c_d.relem  = mem_rdata[ELEM_W-1:0];
                    c_d.d.head = c_q.d.head + ELEM_W'(1);
                    c_d.d.cnt  = c_q.d.cnt - CW'(1);
                    fin        = 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        if (fin) begin
            c_d.st   = ST_IDLE;
            c_d.rv   = 1'b1;
            c_d.rok  = 1'b1;
            st_we    = 1'b1;
            st_idx   = c_q.q;
            st_wdata = c_d.d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy      = (c_q.st != ST_IDLE);
    assign rsp_valid = c_q.rv;
    assign rsp_ok    = c_q.rok;
    assign rsp_empty = c_q.remp;
    assign rsp_full  = c_q.rfull;
    assign rsp_elem  = c_q.relem;
endmodule

// File: rtl/qdesc_engine_chk.sv
module qdesc_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic rsp_valid,
    input logic rsp_ok,
    input logic rsp_empty,
    input logic rsp_full
);
    // R8: one outcome per response
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_ok, rsp_empty, rsp_full}) == 1);

    // R8: outcome flags silent between responses
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_ok || rsp_empty || rsp_full));

    // R7: no response while a command is still in progress
    a_r7_no_rsp_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_valid);

    // R7: leaving busy always reports
    a_r7_end_reports: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    // R6: empty answer comes straight from an accepted command
    a_r6_empty_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_empty |-> $past(cmd_valid && !busy));

    // R5: full answer comes straight from an accepted command
    a_r5_full_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_full |-> $past(cmd_valid && !busy));
endmodule

bind qdesc_engine qdesc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_empty (rsp_empty),
    .rsp_full  (rsp_full)
);

// File: tb/qdesc_engine_bench.sv
module qdesc_engine_bench;
    localparam int NQ  = 4;
    localparam int EW  = 5;
    localparam int LAT = 3;
    localparam int QW  = $clog2(NQ);
    localparam int LGW = $clog2(EW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [QW-1:0] cmd_queue = '0;
    logic [EW-1:0] cmd_elem = '0;
    logic          cfg_ring = 1'b0;
    logic [EW-1:0] cfg_base = '0;
    logic [LGW-1:0] cfg_size_lg = '0;
    logic          busy, rsp_valid, rsp_ok, rsp_empty, rsp_full;
    logic [EW-1:0] rsp_elem;

    always #10 clk = ~clk;   // 50 MHz

    qdesc_engine #(.NUM_Q(NQ), .ELEM_W(EW), .MEM_LAT(LAT)) u_qdesc_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_queue(cmd_queue), .cmd_elem(cmd_elem), .cfg_ring(cfg_ring),
        .cfg_base(cfg_base), .cfg_size_lg(cfg_size_lg), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_empty(rsp_empty),
        .rsp_full(rsp_full), .rsp_elem(rsp_elem)
    );

    int total = 0;
    int bad   = 0;

    // bench model
    int mdat [NQ][64];
    int mrd  [NQ];
    int mcnt [NQ];
    int mcap [NQ];   // 0 = list
    int lnext[NQ];

    function automatic void chk(input bit good, input string req, input int act, input int exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // issue one command, wait for its response; poke drives a stray command while busy
    task automatic run(input int op, input int q, input int el, input int rg, input int bs,
                       input int lg, input bit poke,
                       output bit r_ok, output bit r_emp, output bit r_full,
                       output int r_el, output int waitc, output bit busy_ok);
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = 2'(op);
        cmd_queue   = QW'(q);
        cmd_elem    = EW'(el);
        cfg_ring    = rg[0];
        cfg_base    = EW'(bs);
        cfg_size_lg = LGW'(lg);
        @(negedge clk);
        cmd_valid = 1'b0;
        waitc     = 0;
        busy_ok   = 1'b1;
        while (!rsp_valid && waitc < 60) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && waitc == 0) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'd1;
                cmd_queue = QW'(2);
                cmd_elem  = EW'(9);
            end else begin
                cmd_valid = 1'b0;
            end
            waitc++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        r_ok  = rsp_ok;
        r_emp = rsp_empty;
        r_full = rsp_full;
        r_el  = int'(rsp_elem);
        if (!rsp_valid) busy_ok = 1'b0;
    endtask

    task automatic do_cfg(input int q, input int rg, input int bs, input int lg);
        bit ok, em, fu, bo; int el, w;
        run(0, q, 0, rg, bs, lg, 1'b0, ok, em, fu, el, w, bo);
        chk(ok && !em && !fu, "R2 cfg ok flag", int'(ok), 1);
        chk(w == 0, "R2 cfg immediate", w, 0);
        mrd[q] = 0; mcnt[q] = 0; mcap[q] = rg ? (1 << lg) : 0;
    endtask

    task automatic do_enq(input int q, input int el, input bit poke);
        bit ok, em, fu, bo; int re, w;
        bit exp_full;
        exp_full = (mcap[q] != 0) && (mcnt[q] == mcap[q]);
        run(1, q, el, 0, 0, 0, poke, ok, em, fu, re, w, bo);
        if (exp_full) begin
            chk(fu && !ok && !em, "R5 full flag", int'(fu), 1);
            chk(w == 0, "R5 full immediate", w, 0);
        end else begin
            chk(ok && !fu && !em, mcap[q] != 0 ? "R4 ring enq ok" : "R3 list enq ok", int'(ok), 1);
            chk(w > 0 && bo, "R7 busy through enq", w, LAT);
            mdat[q][(mrd[q] + mcnt[q]) % 64] = el;
            mcnt[q]++;
        end
    endtask

    task automatic do_deq(input int q);
        bit ok, em, fu, bo; int re, w;
        run(2, q, 0, 0, 0, 0, 1'b0, ok, em, fu, re, w, bo);
        if (mcnt[q] == 0) begin
            chk(em && !ok && !fu, "R6 empty flag", int'(em), 1);
            chk(w == 0, "R6 empty immediate", w, 0);
        end else begin
            chk(ok && !em && !fu, "R9 deq ok flag", int'(ok), 1);
            chk(re == mdat[q][mrd[q]], mcap[q] != 0 ? "R4 ring order" : "R3 list order",
                re, mdat[q][mrd[q]]);
            chk(w > 0 && bo, "R7 busy through deq", w, LAT);
            mrd[q] = (mrd[q] + 1) % 64;
            mcnt[q]--;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R7 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int q = 0; q < NQ; q++) begin
            mrd[q] = 0; mcnt[q] = 0; mcap[q] = 0; lnext[q] = 0;
        end
        repeat (3) @(negedge clk);
        chk(!busy, "R1 busy after reset", int'(busy), 0);
        chk(!rsp_valid, "R1 no response after reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rsp_valid, "R1 idle after release", int'(busy), 0);
        for (int q = 0; q < NQ; q++) do_deq(q);   // R1: empty after reset

        // R2: lists on 0/2 (elements 0..7 and 8..15), rings on 1 (16..19) and 3 (24..31)
        do_cfg(0, 0, 0, 0);
        do_cfg(1, 1, 16, 2);
        do_cfg(2, 0, 0, 0);
        do_cfg(3, 1, 24, 3);

        // R5: fill ring 1 past capacity
        for (int i = 0; i < 5; i++) do_enq(1, 20 + i, 1'b0);
        for (int i = 0; i < 5; i++) do_deq(1);

        // R4: wrap sweep
        for (int r = 0; r < 10; r++) begin
            for (int i = 0; i < 3; i++) do_enq(1, (r * 3 + i) % 32, 1'b0);
            for (int i = 0; i < 3; i++) do_deq(1);
        end

        // R3 single element, then R7 stray command while busy
        do_enq(0, 5, 1'b0);
        do_deq(0);
        do_deq(0);
        do_enq(0, 3, 1'b1);          // stray add to queue 2 must be dropped
        do_deq(2);                   // R7: queue 2 still empty
        do_deq(0);

        // R9: interleaved mix across all queues
        lnext[0] = 0; lnext[2] = 8;
        for (int i = 0; i < 80; i++) begin
            int q;
            q = (i * 7 + 3) % 4;
            if ((i * 5) % 3 == 0) do_deq(q);
            else if (mcap[q] != 0) do_enq(q, (i * 11) % 32, 1'b0);
            else if (mcnt[q] < 8) begin
                do_enq(q, lnext[q], 1'b0);
                lnext[q] = (q == 0) ? (lnext[q] + 1) % 8 : 8 + (lnext[q] - 7) % 8;
            end else do_deq(q);
        end

        // R2: reconfigure a non-empty ring, it must read back empty
        do_enq(3, 17, 1'b0);
        do_cfg(3, 1, 24, 3);
        do_deq(3);
        do_enq(3, 30, 1'b0);
        do_deq(3);

        // drain everything
        for (int q = 0; q < NQ; q++) begin
            while (mcnt[q] > 0) do_deq(q);
            do_deq(q);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule